// File: doc/BRIEF.md
# Time-Slice Stream Packetizer

The packetizer sits between a sensor data source and a UDP channel multiplexer. The source delivers a continuous stream of opaque data words, DATA_W bits wide, where DATA_W is a multiple of 16. The words are grouped into time slices, and the source marks the last word of every slice. The block cuts each slice into chunks that never exceed the configured maximum payload. Each chunk is emitted as one packet: a short header comes first and the payload follows. The data is never mixed across slices. The output stream marks the first and last word of every packet for the multiplexer.

The header holds three fields: a 32-bit slice identifier, a 16-bit packet index, and a 16-bit payload length in bytes. The header is packed most-significant field first across as many output words as it needs. The packet index counts packets within one slice and starts again at zero for each new slice. The source presents a per-slice info word together with the first word of the slice. Only the first packet of the slice carries that info word, placed directly after the header, and it counts toward that packet's payload.

The block holds one chunk in a buffer. While it fills the buffer it accepts input words. While it sends a packet out it stalls the input. The output may be held back at any time. When `m_valid` is high and `m_ready` is low, every output stays unchanged. A word moves on either interface only in a cycle where both valid and ready are high.

Top module: `ts_packetizer`

## Requirements
- R1: After reset, `s_ready` is 1 and `m_valid` is 0.
- R2: Each packet begins with the header {slice id[31:0], packet index[15:0], payload length[15:0]}, packed MSB first into DATA_W-bit words. With DATA_W=32, word 0 is the slice id and word 1 is (index << 16) | length.
- R3: The first packet of a slice carries the slice's info word directly after the header. Later packets of the same slice carry no info word.
- R4: The payload, counting the info word, never exceeds MAX_PAYLOAD_BYTES/(DATA_W/8) words. A packet closes as soon as it is full, so the first packet holds at most one data word fewer than later packets.
- R5: A packet closes on the word marked `s_last`, so it never mixes data from two slices. The final packet of a slice may be short. A slice that ends exactly at a full chunk produces no empty extra packet.
- R6: The packet index is 0 for the first packet of every slice and increases by 1 for each further packet of that slice.
- R7: The length field equals the number of payload bytes after the header, counting the info word: payload words × DATA_W/8.
- R8: `m_sop` is high only on the first header word, and `m_eop` only on the last payload word. Each packet has exactly one of each.
- R9: While `m_valid` is high and `m_ready` is low, `m_data`, `m_sop`, `m_eop` and `m_valid` hold their values.
- R10: `s_ready` is low while a packet is being emitted. A word offered during that time is not consumed, and it is taken once `s_ready` returns high.
- R11: The slice id and info word are sampled only with the first word of a slice. Their values on later words of the slice have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| s_valid | input | 1 | Input word valid |
| s_ready | output | 1 | Block can take an input word |
| s_data | input | DATA_W | Opaque sensor data word |
| s_last | input | 1 | Marks the last word of the current time slice |
| s_slice_id | input | 32 | Slice identifier, sampled on the first word of a slice |
| s_info | input | DATA_W | Per-slice info word, sampled on the first word of a slice |
| m_valid | output | 1 | Output word valid |
| m_ready | input | 1 | Multiplexer can take an output word |
| m_data | output | DATA_W | Header, info or payload word |
| m_sop | output | 1 | First word of a packet |
| m_eop | output | 1 | Last word of a packet |

## Verification
Slices of 1, 3, 15, 31 and 40 words are sent in turn. Each length probes a different boundary:
- 1 and 3 words give a single short packet.
- 15 words fill the first packet exactly, once the info word is counted.
- 31 words fill two packets exactly and must not produce an empty third packet.
- 40 words give a short tail packet after two full ones.

Two slices are also sent back to back, so the second slice's first word waits behind a draining packet. That run shows the index restarts, and that ignored id and info values on later words leave no trace. A pattern of output stalls shows whether words hold steady, and whether any word is lost or repeated under back-pressure.

// File: rtl/tsp_pkg.sv
package tsp_pkg;

  typedef struct packed {
    logic [31:0] slice_id;
    logic [15:0] index;
    logic [15:0] len_bytes;
  } tsp_hdr_t;

  typedef enum logic {
    ST_FILL  = 1'b0,
    ST_DRAIN = 1'b1
  } tsp_state_e;

  typedef enum logic [1:0] {
    SRC_HDR  = 2'd0,
    SRC_INFO = 2'd1,
    SRC_BUF  = 2'd2
  } tsp_src_e;

endpackage

// File: rtl/tsp_chunk_buf.sv
module tsp_chunk_buf #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/tsp_hdr_sel.sv
module tsp_hdr_sel
  import tsp_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int HDR_WORDS = 2,
  localparam int HIW      = (HDR_WORDS > 1) ? $clog2(HDR_WORDS) : 1,
  localparam int EXT_W    = HDR_WORDS * DATA_W
) (
  input  tsp_hdr_t          hdr,
  input  logic [HIW-1:0]    sel,
  output logic [DATA_W-1:0] word
);

  logic [EXT_W-1:0]  hdr_ext;
  logic [DATA_W-1:0] words [HDR_WORDS];

  // header left-aligned, zero padding in the tail of the last word
  assign hdr_ext = EXT_W'(hdr) << (EXT_W - 64);

  for (genvar g = 0; g < HDR_WORDS; g++) begin : g_word
    assign words[g] = hdr_ext[(HDR_WORDS-1-g)*DATA_W +: DATA_W];
  end

  assign word = words[sel];

endmodule

// File: rtl/tsp_ctrl.sv
module tsp_ctrl
  import tsp_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int CHUNK_WORDS = 16,
  parameter int HDR_WORDS   = 2,
  localparam int CW_W  = $clog2(CHUNK_WORDS + 1),
  localparam int POS_W = $clog2(HDR_WORDS + CHUNK_WORDS + 1),
  localparam int AW    = (CHUNK_WORDS > 1) ? $clog2(CHUNK_WORDS) : 1,
  localparam int HIW   = (HDR_WORDS > 1) ? $clog2(HDR_WORDS) : 1,
  localparam int BPW   = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic              s_last,
  input  logic [31:0]       s_slice_id,
  input  logic [DATA_W-1:0] s_info,
  output logic              m_valid,
  input  logic              m_ready,
  output logic              m_sop,
  output logic              m_eop,
  output tsp_hdr_t          hdr,
  output logic [HIW-1:0]    hdr_sel,
  output tsp_src_e          src_sel,
  output logic [DATA_W-1:0] info,
  output logic              wr_en,
  output logic [AW-1:0]     wr_addr,
  output logic [AW-1:0]     rd_addr
);

  tsp_state_e        state;
  logic [CW_W-1:0]   cnt;
  logic              slice_open;
  logic              has_info;
  logic [31:0]       cur_slice;
  logic [DATA_W-1:0] cur_info;
  logic [15:0]       pkt_idx;
  logic [POS_W-1:0]  pos;

  logic              accept, starts_slice, info_eff, close, beat, at_last;
  logic [CW_W-1:0]   cap;
  logic [POS_W-1:0]  plen_words, last_pos;

  assign s_ready      = (state == ST_FILL);
  assign m_valid      = (state == ST_DRAIN);
  assign accept       = s_ready && s_valid;
  assign starts_slice = !slice_open;
  assign info_eff     = starts_slice || has_info;
  assign cap          = info_eff ? CW_W'(CHUNK_WORDS - 1) : CW_W'(CHUNK_WORDS);
  assign close        = accept && (s_last || ((cnt + CW_W'(1)) == cap));

  assign plen_words   = POS_W'(cnt) + POS_W'(has_info);
  assign last_pos     = POS_W'(HDR_WORDS) + plen_words - POS_W'(1);
  assign beat         = m_valid && m_ready;
  assign at_last      = (pos == last_pos);

  assign m_sop        = m_valid && (pos == '0);
  assign m_eop        = m_valid && at_last;

  assign hdr.slice_id  = cur_slice;
  assign hdr.index     = pkt_idx;
  assign hdr.len_bytes = 16'(plen_words) * 16'(BPW);
  assign hdr_sel       = HIW'(pos);
  assign info          = cur_info;

  always_comb begin
    if (pos < POS_W'(HDR_WORDS))                        src_sel = SRC_HDR;
    else if (has_info && (pos == POS_W'(HDR_WORDS)))    src_sel = SRC_INFO;
    else                                                src_sel = SRC_BUF;
  end

  assign rd_addr = AW'(pos - POS_W'(HDR_WORDS) - POS_W'(has_info));
  assign wr_en   = accept;
  assign wr_addr = AW'(cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_FILL;
      cnt        <= '0;
      slice_open <= 1'b0;
      has_info   <= 1'b0;
      cur_slice  <= '0;
      cur_info   <= '0;
      pkt_idx    <= '0;
      pos        <= '0;
    end else if (state == ST_FILL) begin
      if (accept) begin
        cnt <= cnt + CW_W'(1);
        if (starts_slice) begin
          cur_slice  <= s_slice_id;
          cur_info   <= s_info;
          has_info   <= 1'b1;
          pkt_idx    <= '0;
          slice_open <= 1'b1;
        end
        if (close) begin
          state <= ST_DRAIN;
          pos   <= '0;
          if (s_last) slice_open <= 1'b0;
        end
      end
    end else if (beat) begin
      if (at_last) begin
        state    <= ST_FILL;
        cnt      <= '0;
        has_info <= 1'b0;
        pkt_idx  <= pkt_idx + 16'd1;
      end else begin
        pos <= pos + POS_W'(1);
      end
    end
  end

  // R4: payload including the info word stays within one chunk
  a_r4_chunk_cap: assert property (@(posedge clk) disable iff (!rst_n)
    plen_words <= POS_W'(CHUNK_WORDS));

  // R3: an info word is only ever pending for the first packet of a slice
  a_r3_info_first_only: assert property (@(posedge clk) disable iff (!rst_n)
    has_info |-> (pkt_idx == 16'd0));

  // R6: each finished packet advances the index by one
  a_r6_index_step: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && m_eop) |=> (pkt_idx == $past(pkt_idx) + 16'd1));

  // R5: the last word of a slice closes the packet at once
  a_r5_slice_close: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && s_last) |=> (m_valid && m_sop));

  // R8: after the end-of-packet word is taken, output goes idle
  a_r8_eop_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && m_eop) |=> !m_valid);

endmodule

// File: rtl/ts_packetizer.sv
module ts_packetizer
  import tsp_pkg::*;
#(
  parameter int DATA_W            = 32,
  parameter int MAX_PAYLOAD_BYTES = 64,
  localparam int BPW         = DATA_W / 8,
  localparam int CHUNK_WORDS = MAX_PAYLOAD_BYTES / BPW,
  localparam int HDR_WORDS   = (64 + DATA_W - 1) / DATA_W,
  localparam int AW          = (CHUNK_WORDS > 1) ? $clog2(CHUNK_WORDS) : 1,
  localparam int HIW         = (HDR_WORDS > 1) ? $clog2(HDR_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_last,
  input  logic [31:0]       s_slice_id,
  input  logic [DATA_W-1:0] s_info,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data,
  output logic              m_sop,
  output logic              m_eop
);

  tsp_hdr_t          hdr;
  logic [HIW-1:0]    hdr_sel;
  tsp_src_e          src_sel;
  logic [DATA_W-1:0] info, hdr_word, buf_word;
  logic              wr_en;
  logic [AW-1:0]     wr_addr, rd_addr;

  tsp_ctrl #(
    .DATA_W(DATA_W), .CHUNK_WORDS(CHUNK_WORDS), .HDR_WORDS(HDR_WORDS)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .s_valid(s_valid), .s_ready(s_ready), .s_last(s_last),
    .s_slice_id(s_slice_id), .s_info(s_info),
    .m_valid(m_valid), .m_ready(m_ready), .m_sop(m_sop), .m_eop(m_eop),
    .hdr(hdr), .hdr_sel(hdr_sel), .src_sel(src_sel), .info(info),
    .wr_en(wr_en), .wr_addr(wr_addr), .rd_addr(rd_addr)
  );

  tsp_chunk_buf #(.DATA_W(DATA_W), .DEPTH(CHUNK_WORDS)) u_buf (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(s_data),
    .rd_addr(rd_addr), .rd_data(buf_word)
  );

  tsp_hdr_sel #(.DATA_W(DATA_W), .HDR_WORDS(HDR_WORDS)) u_hdr (
    .hdr(hdr), .sel(hdr_sel), .word(hdr_word)
  );

  always_comb begin
    unique case (src_sel)
      SRC_HDR:  m_data = hdr_word;
      SRC_INFO: m_data = info;
      default:  m_data = buf_word;
    endcase
  end

  // R9: a stalled output word holds until taken
  a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_sop) && $stable(m_eop)));

endmodule

// File: tb/test_ts_packetizer.sv
module test_ts_packetizer;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int CW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic s_valid = 1'b0, s_last = 1'b0, m_ready = 1'b0;
  logic [DW-1:0] s_data = '0, s_info = '0;
  logic [31:0] s_slice_id = '0;
  logic s_ready, m_valid, m_sop, m_eop;
  logic [DW-1:0] m_data;

  int checks = 0, errors = 0;
  int cyc = 0;
  bit rdy_mode = 1'b0;
  int stall_bad = 0, overlap_bad = 0;
  bit prev_stall = 1'b0;
  logic [DW-1:0] prev_data;
  bit prev_sop, prev_eop;

  logic [31:0] got_d[$], exp_d[$];
  bit got_s[$], got_e[$], exp_s[$], exp_e[$];
  int exp_pkts;

  ts_packetizer #(.DATA_W(DW), .MAX_PAYLOAD_BYTES(64)) i_ts_packetizer (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_last(s_last), .s_slice_id(s_slice_id), .s_info(s_info),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .m_sop(m_sop), .m_eop(m_eop)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // output collector and stall observer
  always begin
    @(negedge clk);
    cyc++;
    m_ready = rdy_mode ? ((cyc % 3) != 0) : 1'b1;
    #1;
    if (prev_stall && (!m_valid || m_data != prev_data || m_sop != prev_sop || m_eop != prev_eop))
      stall_bad++;
    if (s_ready && m_valid) overlap_bad++;
    if (m_valid && m_ready) begin
      got_d.push_back(m_data); got_s.push_back(m_sop); got_e.push_back(m_eop);
    end
    prev_stall = m_valid && !m_ready;
    prev_data = m_data; prev_sop = m_sop; prev_eop = m_eop;
  end

  task automatic build_exp(input logic [31:0] id, input logic [31:0] inf, input int n, input logic [31:0] base);
    int rem = n, done = 0;
    logic [15:0] idx = 0;
    bit first = 1'b1;
    while (rem > 0) begin
      int cap = first ? CW - 1 : CW;
      int take = (rem < cap) ? rem : cap;
      int len = (take + (first ? 1 : 0)) * 4;
      exp_d.push_back(id);                      exp_s.push_back(1'b1); exp_e.push_back(1'b0);
      exp_d.push_back({idx, 16'(len)});         exp_s.push_back(1'b0); exp_e.push_back(1'b0);
      if (first) begin
        exp_d.push_back(inf); exp_s.push_back(1'b0); exp_e.push_back(1'b0);
      end
      for (int k = 0; k < take; k++) begin
        exp_d.push_back(base + 32'(done + k));
        exp_s.push_back(1'b0); exp_e.push_back(k == take - 1);
      end
      done += take; rem -= take; idx++; first = 1'b0; exp_pkts++;
    end
  endtask

  // later words carry junk id/info that must be ignored (R11)
  task automatic send_slice(input logic [31:0] id, input logic [31:0] inf, input int n, input logic [31:0] base);
    build_exp(id, inf, n, base);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      s_valid = 1'b1; s_data = base + 32'(k); s_last = (k == n - 1);
      s_slice_id = (k == 0) ? id : ~id;
      s_info = (k == 0) ? inf : 32'hBAD0_0000 + 32'(k);
      #1;
      while (!s_ready) begin @(negedge clk); #1; end
    end
    @(negedge clk);
    s_valid = 1'b0; s_last = 1'b0;
  endtask

  task automatic start_run();
    got_d.delete(); got_s.delete(); got_e.delete();
    exp_d.delete(); exp_s.delete(); exp_e.delete();
    exp_pkts = 0;
  endtask

  task automatic finish_run(string req);
    int bad_d = 0, bad_f = 0, sops = 0;
    repeat (2) @(negedge clk);
    #2;
    while (m_valid) begin @(negedge clk); #2; end
    chk(got_d.size() == exp_d.size(), req, "word count", 32'(got_d.size()), 32'(exp_d.size()));
    for (int i = 0; i < got_d.size() && i < exp_d.size(); i++) begin
      if (got_d[i] !== exp_d[i]) begin
        if (bad_d == 0) $display("FAIL %s word %0d: actual=%0h expected=%0h", req, i, got_d[i], exp_d[i]);
        bad_d++;
      end
      if (got_s[i] != exp_s[i] || got_e[i] != exp_e[i]) bad_f++;
      if (got_s[i]) sops++;
    end
    chk(bad_d == 0, req, "mismatching words", 32'(bad_d), 0);
    chk(bad_f == 0, {req, " R8"}, "sop/eop mismatches", 32'(bad_f), 0);
    chk(sops == exp_pkts, {req, " R8"}, "packet count", 32'(sops), 32'(exp_pkts));
  endtask

  task automatic t_reset();
    #2;
    chk(s_ready == 1'b1, "R1", "s_ready after reset", 32'(s_ready), 1);
    chk(m_valid == 1'b0, "R1", "m_valid after reset", 32'(m_valid), 0);
  endtask

  task automatic t_short();     // R2 R3 R7: one short packet with info
    start_run(); send_slice(32'h0000_0100, 32'h1A1A_0001, 3, 32'h1000); finish_run("R2 R3 R7");
  endtask

  task automatic t_first_full(); // R4: 15 data + info fill the first packet
    start_run(); send_slice(32'h0000_0200, 32'h2B2B_0002, 15, 32'h2000); finish_run("R4 R7");
  endtask

  task automatic t_long();      // R4 R6: 15 + 16 + 9
    start_run(); send_slice(32'h0000_0300, 32'h3C3C_0003, 40, 32'h3000); finish_run("R4 R6");
  endtask

  task automatic t_exact_two(); // R5: 31 words end on a full chunk, no empty tail
    start_run(); send_slice(32'h0000_0400, 32'h4D4D_0004, 31, 32'h4000); finish_run("R5");
  endtask

  task automatic t_single();    // R5 R7: one-word slice
    start_run(); send_slice(32'h0000_0500, 32'h5E5E_0005, 1, 32'h5000); finish_run("R5 R7");
  endtask

  task automatic t_stall();     // R9 R10: output back-pressure
    rdy_mode = 1'b1;
    start_run(); send_slice(32'h0000_0600, 32'h6F6F_0006, 20, 32'h6000); finish_run("R9 R10");
    rdy_mode = 1'b0;
    chk(stall_bad == 0, "R9", "outputs changed while stalled", 32'(stall_bad), 0);
    chk(overlap_bad == 0, "R10", "s_ready high during packet output", 32'(overlap_bad), 0);
  endtask

  task automatic t_back_to_back(); // R6 R10 R11: index restarts, held word not lost
    rdy_mode = 1'b1;
    start_run();
    send_slice(32'h0000_0700, 32'h7070_0007, 18, 32'h7000);
    send_slice(32'h0000_0701, 32'h7171_0008, 5, 32'h7100);
    finish_run("R6 R10 R11");
    rdy_mode = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_short();
    t_first_full();
    t_long();
    t_exact_two();
    t_single();
    t_stall();
    t_back_to_back();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule